// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block carries out the sixteen integer data-processing operations of a 32-bit RISC core and works out the new negative, zero, carry and overflow flags. The first operand comes from a register. The second operand arrives already shifted or rotated by an upstream shifter, and the shifter's carry-out arrives with it. A separate select line runs a count-leading-zeros operation on the second operand instead of the selected opcode.

The block has one register stage. Operands presented in a cycle with `in_valid` high produce the result, the write enable and the flags on the next rising clock edge. The caller supplies the current flag values. When an operation leaves the flags alone, the block passes those values through unchanged, so the flag outputs can feed the status register directly.

Top module: `dpalu_core`

## Requirements
- R1: For opcodes SUB (2), RSB (3), ADD (4) and CMP (10), the result is opa-opb, opb-opa, opa+opb and opa-opb respectively. CMN (11) gives opa+opb. All results are taken modulo 2^32.
- R2: ADC (5) adds cur_c to opa+opb. SBC (6) computes opa-opb-(1-cur_c). RSC (7) computes opb-opa-(1-cur_c).
- R3: For the arithmetic opcodes (2 to 7, 10, 11), the new C is the unsigned carry-out of an addition. For a subtraction, C is 1 exactly when the minuend is greater than or equal to the subtrahend plus the borrow.
- R4: For the arithmetic opcodes, the new V is 1 exactly when the signed (two's complement) value of the exact result lies outside the range -2^31 to 2^31-1.
- R5: The logical opcodes give these results: AND (0) and TST (8) give opa&opb. EOR (1) and TEQ (9) give opa^opb. ORR (12) gives opa|opb. MOV (13) gives opb. BIC (14) gives opa&~opb. MVN (15) gives ~opb.
- R6: For the logical opcodes, V keeps cur_v. The new C takes cur_c when imm_form=1 and rot_nonzero=0; in every other case it takes shift_cout.
- R7: Whenever the flags are updated, N equals result bit 31 and Z is 1 exactly when the 32-bit result is zero.
- R8: Opcodes 8 to 11 hold wr_en low, but the result port still shows the computed value. These opcodes always update the flags, whatever set_flags is.
- R9: For opcodes outside 8 to 11, the flags are updated only when set_flags=1. Otherwise flag_n, flag_z, flag_c and flag_v equal cur_n, cur_z, cur_c and cur_v.
- R10: With clz_sel=1, the opcode is ignored. The result is the number of zero bits above the most significant set bit of opb, and 32 when opb is zero. wr_en is 1 and the flags pass through unchanged.
- R11: Outputs change one clock edge after an operation is accepted. out_valid follows in_valid one cycle later. After reset, out_valid, wr_en, result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Data-processing opcode |
| clz_sel | input | 1 | Run count-leading-zeros on opb instead |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, already shifted |
| shift_cout | input | 1 | Carry out of the shifter or rotator |
| imm_form | input | 1 | Second operand is a rotated immediate |
| rot_nonzero | input | 1 | Immediate rotation amount is nonzero |
| set_flags | input | 1 | Request a flag update |
| cur_n | input | 1 | Current N flag |
| cur_z | input | 1 | Current Z flag |
| cur_c | input | 1 | Current C flag |
| cur_v | input | 1 | Current V flag |
| out_valid | output | 1 | Registered outputs belong to an accepted operation |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Result is to be written to the destination |
| flag_n | output | 1 | New N flag |
| flag_z | output | 1 | New Z flag |
| flag_c | output | 1 | New C flag |
| flag_v | output | 1 | New V flag |

## Verification
The result, wr_en, the four flags and out_valid are all due on the first rising edge after the cycle in which the operation is presented. The bench drives each operation on a falling edge and compares every output on the next falling edge, half a cycle after the capturing edge. Operations are issued back to back, so any extra pipeline stage or missing register would show up as a mismatch against the preceding operation's expected values.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
      OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
      OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
      OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
   } dp_op_e;

   // flag-only group 8..B
   function automatic logic op_is_test(input logic [3:0] op);
      return op[3:2] == 2'b10;
   endfunction

   function automatic logic op_is_arith(input logic [3:0] op);
      return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
                         OP_CMP, OP_CMN});
   endfunction

endpackage

// File: rtl/dpalu_addsub.sv
module dpalu_addsub
   import dpalu_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [3:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          cin,
   output logic [DW-1:0] sum,
   output logic          cout,
   output logic          ovf
);

   logic [DW-1:0] x, y;
   logic          ci;
   logic [DW:0]   full;

   // every subtraction becomes x + ~y + carry
   always_comb begin
      x  = a;
      y  = b;
      ci = 1'b0;
      unique case (op)
         OP_SUB, OP_CMP: begin x = a; y = ~b; ci = 1'b1; end
         OP_RSB:         begin x = b; y = ~a; ci = 1'b1; end
         OP_ADC:         begin x = a; y = b;  ci = cin;  end
         OP_SBC:         begin x = a; y = ~b; ci = cin;  end
         OP_RSC:         begin x = b; y = ~a; ci = cin;  end
         default:        begin x = a; y = b;  ci = 1'b0; end
      endcase
   end

   assign full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
   assign sum  = full[DW-1:0];
   assign cout = full[DW];
   assign ovf  = (x[DW-1] == y[DW-1]) && (sum[DW-1] != x[DW-1]);

endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
   import dpalu_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [3:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] res
);

   always_comb begin
      unique case (op)
         OP_AND, OP_TST: res = a & b;
         OP_EOR, OP_TEQ: res = a ^ b;
         OP_ORR:         res = a | b;
         OP_MOV:         res = b;
         OP_BIC:         res = a & ~b;
         OP_MVN:         res = ~b;
         default:        res = '0;
      endcase
   end

endmodule

// File: rtl/dpalu_clz.sv
module dpalu_clz #(
   parameter int DW = 32,
   parameter int CW = $clog2(DW + 1)
) (
   input  logic [DW-1:0] a,
   output logic [CW-1:0] cnt
);

   // scan upward so the highest set bit wins
   always_comb begin
      cnt = CW'(DW);
      for (int i = 0; i < DW; i++) begin
         if (a[i]) cnt = CW'(DW - 1 - i);
      end
   end

endmodule

// File: rtl/dpalu_core.sv
module dpalu_core
   import dpalu_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [3:0]    opcode,
   input  logic          clz_sel,
   input  logic [DW-1:0] opa,
   input  logic [DW-1:0] opb,
   input  logic          shift_cout,
   input  logic          imm_form,
   input  logic          rot_nonzero,
   input  logic          set_flags,
   input  logic          cur_n,
   input  logic          cur_z,
   input  logic          cur_c,
   input  logic          cur_v,
   output logic          out_valid,
   output logic [DW-1:0] result,
   output logic          wr_en,
   output logic          flag_n,
   output logic          flag_z,
   output logic          flag_c,
   output logic          flag_v
);

   localparam int CW = $clog2(DW + 1);

   generate
      if (DW < 8) begin : g_bad_width
         $error("dpalu_core: DW must be at least 8");
      end
   endgenerate

   logic [DW-1:0] as_sum, lg_res, res_nxt;
   logic          as_cout, as_ovf;
   logic [CW-1:0] clz_cnt;
   logic          is_arith, is_test, upd, wr_nxt;
   logic          n_nxt, z_nxt, c_nxt, v_nxt;

   dpalu_addsub #(.DW(DW)) u_addsub (
      .op(opcode), .a(opa), .b(opb), .cin(cur_c),
      .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
   );

   dpalu_logic #(.DW(DW)) u_logic (
      .op(opcode), .a(opa), .b(opb), .res(lg_res)
   );

   dpalu_clz #(.DW(DW), .CW(CW)) u_clz (
      .a(opb), .cnt(clz_cnt)
   );

   always_comb begin
      is_arith = op_is_arith(opcode);
      is_test  = op_is_test(opcode);
      if (clz_sel)       res_nxt = {{(DW-CW){1'b0}}, clz_cnt};
      else if (is_arith) res_nxt = as_sum;
      else               res_nxt = lg_res;
      upd    = !clz_sel && (set_flags || is_test);
      wr_nxt = clz_sel || !is_test;
      if (is_arith) begin
         c_nxt = as_cout;
         v_nxt = as_ovf;
      end else begin
         c_nxt = (imm_form && !rot_nonzero) ? cur_c : shift_cout;
         v_nxt = cur_v;
      end
      n_nxt = res_nxt[DW-1];
      z_nxt = (res_nxt == '0);
      if (!upd) begin
         n_nxt = cur_n;
         z_nxt = cur_z;
         c_nxt = cur_c;
         v_nxt = cur_v;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wr_en     <= 1'b0;
         result    <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_c    <= 1'b0;
         flag_v    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= in_valid && wr_nxt;
         if (in_valid) begin
            result <= res_nxt;
            flag_n <= n_nxt;
            flag_z <= z_nxt;
            flag_c <= c_nxt;
            flag_v <= v_nxt;
         end
      end
   end

   // R8
   test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !clz_sel && opcode[3:2] == 2'b10 |=> !wr_en);

   // R9
   flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !set_flags && opcode[3:2] != 2'b10
      |=> flag_n == $past(cur_n) && flag_z == $past(cur_z)
          && flag_c == $past(cur_c) && flag_v == $past(cur_v));

   // R6
   logic_v_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !clz_sel && (opcode inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF})
      |=> flag_v == $past(cur_v));

   // R7
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !clz_sel && (set_flags || opcode[3:2] == 2'b10)
      |=> flag_z == (result == '0) && flag_n == result[DW-1]);

   // R10
   clz_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && clz_sel && opb == '0 |=> result == DW && wr_en);

   // R11
   write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> out_valid);

endmodule

// File: tb/dpalu_core_tb.sv
module dpalu_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  opcode = '0;
   logic        clz_sel = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic        shift_cout = 1'b0, imm_form = 1'b0, rot_nonzero = 1'b0;
   logic        set_flags = 1'b0;
   logic        cur_n = 1'b0, cur_z = 1'b0, cur_c = 1'b0, cur_v = 1'b0;
   logic        out_valid, wr_en, flag_n, flag_z, flag_c, flag_v;
   logic [31:0] result;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   dpalu_core #(.DW(32)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .clz_sel(clz_sel), .opa(opa), .opb(opb), .shift_cout(shift_cout),
      .imm_form(imm_form), .rot_nonzero(rot_nonzero), .set_flags(set_flags),
      .cur_n(cur_n), .cur_z(cur_z), .cur_c(cur_c), .cur_v(cur_v),
      .out_valid(out_valid), .result(result), .wr_en(wr_en),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic is_arith_op(input logic [3:0] op);
      return (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB;
   endfunction

   // reference computed from the requirements
   task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] r, output logic w, output logic [3:0] nzcv);
      logic [31:0] x, y;
      logic        bor, sub, cin, c, v;
      logic [32:0] full;
      longint      sres;
      x = a; y = b; bor = 0; cin = 0; sub = 0; c = 0; v = cur_v;
      case (op)
         4'h2, 4'hA: begin sub = 1; end
         4'h3:       begin sub = 1; x = b; y = a; end
         4'h6:       begin sub = 1; bor = !cur_c; end
         4'h7:       begin sub = 1; x = b; y = a; bor = !cur_c; end
         4'h5:       cin = cur_c;
         default:    ;
      endcase
      if (is_arith_op(op)) begin
         if (sub) begin
            r    = x - y - {31'd0, bor};
            c    = ({1'b0, x} >= ({1'b0, y} + {32'd0, bor}));
            sres = longint'($signed(x)) - longint'($signed(y)) - longint'(bor);
         end else begin
            full = {1'b0, x} + {1'b0, y} + {32'd0, cin};
            r    = full[31:0];
            c    = full[32];
            sres = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
         end
         v = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
      end else begin
         case (op)
            4'h0, 4'h8: r = a & b;
            4'h1, 4'h9: r = a ^ b;
            4'hC:       r = a | b;
            4'hD:       r = b;
            4'hE:       r = a & ~b;
            default:    r = ~b;
         endcase
         c = (imm_form && !rot_nonzero) ? cur_c : shift_cout;
      end
      w = !(op >= 4'h8 && op <= 4'hB);
      if (set_flags || !w) nzcv = {r[31], r == 32'd0, c, v};
      else                 nzcv = {cur_n, cur_z, cur_c, cur_v};
   endtask

   function automatic string res_tag(input logic [3:0] op);
      if (op == 4'h5 || op == 4'h6 || op == 4'h7) return "R2 carry-in result";
      if (is_arith_op(op)) return "R1 arith result";
      return "R5 logic result";
   endfunction

   function automatic string flag_tag(input logic [3:0] op, input logic w);
      if (w && !set_flags) return "R9 flags kept";
      if (is_arith_op(op)) return "R3/R4/R7 arith flags";
      return "R6/R7 logic flags";
   endfunction

   logic [31:0] pats [8] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFE, 32'h8000_0001};

   initial begin
      logic [31:0] er;
      logic        ew;
      logic [3:0]  ef;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 reset out_valid", {31'd0, out_valid}, 32'd0);
      check("R11 reset wr_en", {31'd0, wr_en}, 32'd0);
      check("R11 reset result", result, 32'd0);
      check("R11 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int op = 0; op < 16; op++)
         for (int sf = 0; sf < 2; sf++)
            for (int ia = 0; ia < 8; ia++)
               for (int ib = 0; ib < 8; ib++)
                  for (int k = 0; k < 6; k++) begin
                     opcode = op[3:0]; set_flags = sf[0];
                     opa = pats[ia]; opb = pats[ib];
                     cur_c = k[0]; cur_v = ~k[0]; cur_n = k[1]; cur_z = ~k[1];
                     imm_form = (k >= 2); rot_nonzero = (k >= 4);
                     shift_cout = ~k[0] ^ k[2];
                     clz_sel = 1'b0; in_valid = 1'b1;
                     model(opcode, opa, opb, er, ew, ef);
                     @(posedge clk);
                     @(negedge clk);
                     check(res_tag(opcode), result, er);
                     check("R8 write enable", {31'd0, wr_en}, {31'd0, ew});
                     check(flag_tag(opcode, ew), {28'd0, flag_n, flag_z, flag_c, flag_v},
                           {28'd0, ef});
                     check("R11 out_valid", {31'd0, out_valid}, 32'd1);
                  end

      // R10 count leading zeros, opcode ignored, flags pass through
      for (int i = -1; i < 32; i++) begin
         clz_sel = 1'b1; opcode = 4'hA; set_flags = 1'b1;
         opb = (i < 0) ? 32'd0 : ((32'd1 << i) | (((32'd1 << i) - 1) & 32'h5A5A_5A5A));
         cur_n = i[0]; cur_z = ~i[0]; cur_c = i[1]; cur_v = ~i[1];
         @(posedge clk);
         @(negedge clk);
         check("R10 clz result", result, (i < 0) ? 32'd32 : 32'(31 - i));
         check("R10 clz write", {31'd0, wr_en}, 32'd1);
         check("R10 clz flags", {28'd0, flag_n, flag_z, flag_c, flag_v},
               {28'd0, cur_n, cur_z, cur_c, cur_v});
      end

      // R11 idle cycle
      in_valid = 1'b0; clz_sel = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R11 idle out_valid", {31'd0, out_valid}, 32'd0);
      check("R11 idle wr_en", {31'd0, wr_en}, 32'd0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule